// File: doc/BRIEF.md
# Two-Path Interrupt Request Combiner

This block gathers pending flags from up to twenty peripheral sources into two request lines for a processor: a normal request and a fast request. Both lines use one shared map of source positions. Each line has its own independent enable set. A source can therefore be routed to the normal line, to the fast line, to both lines, or to neither.

The peripherals own their pending flags and clear them through their own registers. The block only observes these flags and never modifies them. Software reaches the block over a simple word-addressed register bus, with four registers for each path:

- a raw view of the pending flags,
- a write-one-to-set enable register,
- a write-one-to-clear enable register,
- a masked status view.

On the fast path, status bit 0 summarises every other active fast source. Bit 1 is kept for a software interrupt, and bit 15 is reserved. Neither bit 1 nor bit 15 can be enabled.

Top module: `dual_path_intc`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, both enable sets are zero and `irq_o` and `fiq_o` are low.
- R2: Register word addresses are: 0 normal raw, 1 normal set-enable, 2 normal clear-enable, 3 normal status, 4 fast raw, 5 fast set-enable, 6 fast clear-enable, 7 fast status. Read data appears on `bus_rdata` in the cycle after the read strobe, zero-extended.
- R3: Writing to a set-enable address sets every enable bit whose written bit is 1. Bits written as 0 keep their value. Reading a set-enable address returns the enable set of that path.
- R4: Writing to a clear-enable address clears every enable bit whose written bit is 1. A clear-enable address always reads as zero.
- R5: A raw view returns `src_pend` with bits 0, 1 and 15 forced to zero, whatever the enables hold.
- R6: Status bit n (n ≥ 1) of a path equals raw bit n AND that path's enable bit n. The two paths are independent, so a source enabled on both paths appears in both status views.
- R7: Fast status bit 0 is the OR of fast status bits 1 and above. Normal status bit 0 always reads zero.
- R8: Bits 0, 1 and 15 of any set-enable or clear-enable write have no effect. These enable bits stay zero.
- R9: `irq_o` and `fiq_o` go high exactly one clock after any status bit of their path becomes set, and fall one clock after the last one clears.
- R10: A pending source that is enabled on neither path sets no status bit and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pend | input | NSRC | Pending flags from the peripherals |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with its defaults: NSRC = 20 and DATA_W = 32. These values place the reserved position 15, the software position 1 and the top source 19 inside the map, and leave unused upper data bits that must read back as zero. The scoreboard compares all eight registers against a model of both enable sets after each step. This covers overlapping routing, partial set and clear writes, the fast summary bit, and the one-cycle request latency.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int SUM_BIT = 0;
  localparam int SWI_BIT = 1;
  localparam int RSV_BIT = 15;

  typedef enum logic [2:0] {
    A_N_RAW = 3'd0, A_N_SET = 3'd1, A_N_CLR = 3'd2, A_N_STA = 3'd3,
    A_F_RAW = 3'd4, A_F_SET = 3'd5, A_F_CLR = 3'd6, A_F_STA = 3'd7
  } reg_addr_e;

  // Positions that may hold an enable or show a raw flag
  function automatic logic [31:0] live_mask();
    logic [31:0] m;
    m = '1;
    m[SUM_BIT] = 1'b0;
    m[SWI_BIT] = 1'b0;
    m[RSV_BIT] = 1'b0;
    return m;
  endfunction
endpackage

// File: rtl/intc_mask_bank.sv
module intc_mask_bank #(
  parameter int NSRC = 20,
  parameter logic [NSRC-1:0] WMASK = '1,
  parameter bit HAS_SUM = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_we,
  input  logic            clr_we,
  input  logic [NSRC-1:0] wbits,
  input  logic [NSRC-1:0] sig,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] sta,
  output logic            req_q
);
  logic [NSRC-1:0] sta_core;
  logic [NSRC-1:0] set_m, clr_m;

  assign set_m    = set_we ? (wbits & WMASK) : '0;
  assign clr_m    = clr_we ? (wbits & WMASK) : '0;
  assign sta_core = sig & en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      req_q <= 1'b0;
    end else begin
      en_q  <= (en_q | set_m) & ~clr_m;
      req_q <= |sta_core;
    end
  end

  generate
    if (HAS_SUM) begin : g_sum
      assign sta = {sta_core[NSRC-1:1], |sta_core};
    end else begin : g_plain
      assign sta = sta_core;
    end
  endgenerate
endmodule

// File: rtl/intc_regbus.sv
module intc_regbus #(
  parameter int NSRC   = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [NSRC-1:0]   n_sig,
  input  logic [NSRC-1:0]   n_en,
  input  logic [NSRC-1:0]   n_sta,
  input  logic [NSRC-1:0]   f_sig,
  input  logic [NSRC-1:0]   f_en,
  input  logic [NSRC-1:0]   f_sta,
  output logic [1:0]        set_we,
  output logic [1:0]        clr_we,
  output logic [DATA_W-1:0] bus_rdata
);
  import intc_pkg::*;

  logic wr, rd;
  assign wr = bus_sel & bus_we;
  assign rd = bus_sel & ~bus_we;

  assign set_we[0] = wr && (bus_addr == A_N_SET);
  assign set_we[1] = wr && (bus_addr == A_F_SET);
  assign clr_we[0] = wr && (bus_addr == A_N_CLR);
  assign clr_we[1] = wr && (bus_addr == A_F_CLR);

  logic [NSRC-1:0] rmux;
  always_comb begin
    case (bus_addr)
      A_N_RAW: rmux = n_sig;
      A_N_SET: rmux = n_en;
      A_N_STA: rmux = n_sta;
      A_F_RAW: rmux = f_sig;
      A_F_SET: rmux = f_en;
      A_F_STA: rmux = f_sta;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= DATA_W'(rmux);
  end
endmodule

// File: rtl/dual_path_intc.sv
module dual_path_intc #(
  parameter int NSRC   = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_pend,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam logic [NSRC-1:0] WMASK = NSRC'(intc_pkg::live_mask());

  logic [NSRC-1:0] sig;
  logic [NSRC-1:0] en_w  [2];
  logic [NSRC-1:0] sta_w [2];
  logic [1:0]      req_w, set_we, clr_we;
  logic            unused_hi;

  assign sig       = src_pend & WMASK;
  assign unused_hi = ^bus_wdata[DATA_W-1:NSRC];

  generate
    for (genvar p = 0; p < 2; p++) begin : g_path
      intc_mask_bank #(
        .NSRC(NSRC), .WMASK(WMASK), .HAS_SUM(p == 1)
      ) u_bank (
        .clk(clk), .rst(rst),
        .set_we(set_we[p]), .clr_we(clr_we[p]),
        .wbits(bus_wdata[NSRC-1:0]), .sig(sig),
        .en_q(en_w[p]), .sta(sta_w[p]), .req_q(req_w[p])
      );
    end
  endgenerate

  intc_regbus #(.NSRC(NSRC), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .n_sig(sig), .n_en(en_w[0]), .n_sta(sta_w[0]),
    .f_sig(sig), .f_en(en_w[1]), .f_sta(sta_w[1]),
    .set_we(set_we), .clr_we(clr_we), .bus_rdata(bus_rdata)
  );

  assign irq_o = req_w[0];
  assign fiq_o = req_w[1];
endmodule

// File: rtl/dual_path_intc_chk.sv
module dual_path_intc_chk #(
  parameter int NSRC   = 20,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [NSRC-1:0]   src_pend,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [2:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq_o,
  input logic              fiq_o,
  input logic [NSRC-1:0]   n_en,
  input logic [NSRC-1:0]   f_en
);
  localparam logic [NSRC-1:0] WMASK = NSRC'(intc_pkg::live_mask());
  logic [NSRC-1:0] wb;
  assign wb = bus_wdata[NSRC-1:0] & WMASK;

  // R1
  rst_quiet_chk: assert property (@(posedge clk) rst |=> (!irq_o && !fiq_o && n_en == '0 && f_en == '0));
  // R3
  set_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && bus_addr == 3'd1) |=> ((n_en & $past(wb)) == $past(wb)));
  // R4
  clr_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && bus_addr == 3'd6) |=> ((f_en & $past(wb)) == '0));
  // R8
  dead_bits_chk: assert property (@(posedge clk) disable iff (rst)
    ((n_en | f_en) & ~WMASK) == '0);
  // R9
  irq_lag_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_o == $past(|(src_pend & n_en))));
  // R9
  fiq_lag_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (fiq_o == $past(|(src_pend & f_en))));
endmodule

bind dual_path_intc dual_path_intc_chk #(.NSRC(NSRC), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .src_pend(src_pend), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_o(irq_o), .fiq_o(fiq_o),
  .n_en(en_w[0]), .f_en(en_w[1])
);

// File: tb/dual_path_intc_tb.sv
module dual_path_intc_tb;
  localparam int NSRC = 20;
  localparam int DW   = 32;
  localparam logic [NSRC-1:0] VM = 20'hF7FFC; // bits 0,1,15 dead

  logic clk = 0, rst = 1;
  logic [NSRC-1:0] src_pend = '0;
  logic bus_sel = 0, bus_we = 0;
  logic [2:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic irq_o, fiq_o;

  always #2 clk = ~clk;

  dual_path_intc #(.NSRC(NSRC), .DATA_W(DW)) u_dut (.*);

  int checks = 0, errors = 0;
  logic [NSRC-1:0] m_en [2];

  typedef struct { logic [DW-1:0] val; string tag; } exp_t;
  exp_t q[$];
  logic rd_flag = 0;

  always @(posedge clk) rd_flag <= bus_sel && !bus_we;

  // monitor: pops one expectation per returned read
  always @(negedge clk) begin
    if (rd_flag) begin
      exp_t e;
      checks++;
      if (q.size() == 0) begin
        errors++; $display("FAIL %s: unexpected read %h", "R2", bus_rdata);
      end else begin
        e = q.pop_front();
        if (bus_rdata !== e.val) begin
          errors++; $display("FAIL %s: got %h exp %h", e.tag, bus_rdata, e.val);
        end
      end
    end
  end

  function automatic logic [NSRC-1:0] m_sta(input int p);
    logic [NSRC-1:0] s;
    s = src_pend & VM & m_en[p];
    if (p == 1) s[0] = |s[NSRC-1:1];
    return s;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    if (a == 3'd1) m_en[0] = m_en[0] | (d[NSRC-1:0] & VM);
    if (a == 3'd2) m_en[0] = m_en[0] & ~(d[NSRC-1:0] & VM);
    if (a == 3'd5) m_en[1] = m_en[1] | (d[NSRC-1:0] & VM);
    if (a == 3'd6) m_en[1] = m_en[1] & ~(d[NSRC-1:0] & VM);
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [DW-1:0] e, input string tag);
    exp_t x;
    @(negedge clk);
    x.val = e; x.tag = tag; q.push_back(x);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic rd_all(input string tag);
    rd(3'd0, DW'(src_pend & VM), {tag, " R5 nraw"});
    rd(3'd1, DW'(m_en[0]),       {tag, " R3 nen"});
    rd(3'd2, '0,                 {tag, " R4 nclr"});
    rd(3'd3, DW'(m_sta(0)),      {tag, " R6 R7 nsta"});
    rd(3'd4, DW'(src_pend & VM), {tag, " R5 fraw"});
    rd(3'd5, DW'(m_en[1]),       {tag, " R3 fen"});
    rd(3'd6, '0,                 {tag, " R4 fclr"});
    rd(3'd7, DW'(m_sta(1)),      {tag, " R6 R7 fsta"});
  endtask

  task automatic chk_out(input logic ei, input logic ef, input string tag);
    checks++;
    if (irq_o !== ei || fiq_o !== ef) begin
      errors++;
      $display("FAIL %s: irq/fiq %b%b exp %b%b", tag, irq_o, fiq_o, ei, ef);
    end
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    errors++; $display("FAIL watchdog: timeout exp done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_en[0] = '0; m_en[1] = '0;
    repeat (3) @(negedge clk);
    chk_out(0, 0, "R1 in reset");
    rst = 0;
    @(negedge clk);
    chk_out(0, 0, "R1 after reset");
    rd_all("R1 R2");

    // R10 R5: pending with nothing enabled, dead bits driven high
    src_pend = 20'h5A5A4 | 20'h08003;
    @(negedge clk); @(negedge clk);
    chk_out(0, 0, "R10");
    rd_all("R10");

    // R3 R8: enable everything on normal path
    wr(3'd1, 32'hFFFF_FFFF);
    @(negedge clk);
    chk_out(1, 0, "R9 normal up");
    rd_all("R3 R8 all");

    // R4: partial clear, then zero set write changes nothing
    wr(3'd2, 32'h0000_80F2);
    wr(3'd1, 32'h0000_0000);
    rd_all("R4 partial");

    // R6 R7: overlap on fast path
    wr(3'd5, 32'h0000_0C04 | 32'h8002);
    @(negedge clk);
    chk_out(1, 1, "R9 both");
    rd_all("R6 overlap");

    // R6: only bit 12 pending (normal-only)
    src_pend = 20'h01000;
    @(negedge clk); @(negedge clk);
    chk_out(1, 0, "R6 normal only");
    rd_all("R6 single");

    // R9: latency on fast path from idle
    src_pend = '0;
    @(negedge clk); @(negedge clk);
    chk_out(0, 0, "R9 idle");
    src_pend = 20'h00004;
    chk_out(0, 0, "R9 before edge");
    @(negedge clk);
    chk_out(1, 1, "R9 one edge later");
    rd_all("R7 summary");
    src_pend = '0;
    @(negedge clk);
    chk_out(0, 0, "R9 fall");

    // R4 R8: clear fast path entirely incl dead bits
    wr(3'd6, 32'hFFFF_FFFF);
    src_pend = 20'hFFFFF;
    @(negedge clk); @(negedge clk);
    chk_out(1, 0, "R4 fast cleared");
    rd_all("R4 R8 fast");

    // R1: reset mid-run
    rst = 1; m_en[0] = '0; m_en[1] = '0;
    @(negedge clk);
    chk_out(0, 0, "R1 mid reset");
    rst = 0;
    rd_all("R1 post");

    finish_run();
  end
endmodule